// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 16-register, 32-bit word-addressed processor fetches next. Each cycle the surrounding core gives it the current program counter, the 8-bit opcode, the values read from the first and second register operands, and the 16-bit target field of the instruction. The block returns the next program counter, a flag that marks a redirect, and a write request for the link register together with its value. It is purely combinational and has no state of its own.

The block handles several kinds of control flow. Two kinds leave the target field unconditional: a plain jump, and a jump that also writes the return address into the first register operand. A third jumps to the address held in the first register operand. Six conditional branches compare the two register operands directly, with no flags register: equal, not equal, signed greater-than, signed less-or-equal, unsigned greater-than and unsigned less-or-equal. Every other opcode falls through to the next word. The stop opcode raises a halt output and the breakpoint opcode raises a pause output. Neither of them redirects the program counter.

The two register operands are compared either through one shared subtractor or through direct magnitude comparators. A parameter selects which.

Top module: `brn_nextpc_unit`

## Requirements
- R1: For any opcode that is not a control opcode (anything other than 0x01-0x09, 0x10 and 0x82), next_pc_o is pc_i+1 modulo 2^16, and taken_o, link_we_o, halt_o and pause_o are all 0.
- R2: Opcode 0x02 (jump) sets next_pc_o to tgt_i with taken_o=1 and link_we_o=0, whatever the register operands hold.
- R3: Opcode 0x03 (jump and link) sets next_pc_o to tgt_i, taken_o=1 and link_we_o=1. link_val_o is (pc_i+1) modulo 2^16, zero-extended to 32 bits.
- R4: Opcode 0x04 (jump to register) sets next_pc_o to the low 16 bits of rs1_i, with taken_o=1 and link_we_o=0.
- R5: Opcode 0x05 is taken when rs1_i equals rs2_i. Opcode 0x06 is taken when they differ.
- R6: Opcode 0x07 is taken when rs1_i > rs2_i as signed 32-bit values. Opcode 0x08 is taken when rs1_i <= rs2_i as signed values.
- R7: Opcode 0x09 is taken when rs1_i > rs2_i as unsigned values. Opcode 0x10 is taken when rs1_i <= rs2_i as unsigned values.
- R8: A conditional branch that is taken sets next_pc_o to tgt_i. One that is not taken sets next_pc_o to pc_i+1 modulo 2^16 with taken_o=0. A conditional branch never sets link_we_o.
- R9: Opcode 0x01 raises halt_o and opcode 0x82 raises pause_o. Both leave taken_o=0 and link_we_o=0, and both set next_pc_o to pc_i+1 modulo 2^16.
- R10: At pc_i=0xFFFF the fall-through address and the link value both wrap to 0x0000.
- R11: Opcodes 0x0A to 0x0F lie in the gap of the branch numbering and behave as non-control opcodes (R1).
- R12: At most one of taken_o, halt_o and pause_o is 1. link_we_o=1 occurs only together with taken_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 16 | Current word address |
| op_i | input | 8 | Instruction opcode |
| rs1_i | input | 32 | Value of first register operand |
| rs2_i | input | 32 | Value of second register operand |
| tgt_i | input | 16 | Target field of the instruction |
| next_pc_o | output | 16 | Address of the next instruction |
| taken_o | output | 1 | Control flow redirected |
| link_we_o | output | 1 | Write link_val_o into the first register operand |
| link_val_o | output | 32 | Return address, zero-extended |
| halt_o | output | 1 | Stop opcode seen |
| pause_o | output | 1 | Breakpoint opcode seen |

## Verification
Assertions placed beside the logic check four things whenever the inputs change:
- the output exclusivity and the link-implies-taken rule (R12);
- that a not-taken result always yields the incremented address;
- that the comparator flags are consistent, meaning equality excludes greater-than, and signed and unsigned orderings agree when the operand signs match;
- that halt and pause never redirect.

Whether each opcode picks the right condition, and the right polarity of that condition, shows only in the bench scenarios. The same holds for the signed-versus-unsigned split at 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, for the numbering gap, and for wrap-around at the top of the address space.

// File: rtl/brn_pkg.sv
package brn_pkg;

   localparam int OPW = 8;

   localparam logic [OPW-1:0] OP_STOP  = 8'h01;
   localparam logic [OPW-1:0] OP_JMP   = 8'h02;
   localparam logic [OPW-1:0] OP_JAL   = 8'h03;
   localparam logic [OPW-1:0] OP_JR    = 8'h04;
   localparam logic [OPW-1:0] OP_BEQ   = 8'h05;
   localparam logic [OPW-1:0] OP_BNE   = 8'h06;
   localparam logic [OPW-1:0] OP_BGTS  = 8'h07;
   localparam logic [OPW-1:0] OP_BLES  = 8'h08;
   localparam logic [OPW-1:0] OP_BGTU  = 8'h09;
   localparam logic [OPW-1:0] OP_BLEU  = 8'h10;
   localparam logic [OPW-1:0] OP_BRKPT = 8'h82;

   typedef enum logic [2:0] {
      CLS_SEQ,
      CLS_JMP,
      CLS_LINK,
      CLS_REG,
      CLS_COND,
      CLS_HALT,
      CLS_PAUSE
   } brn_cls_e;

   typedef enum logic [2:0] {
      CND_EQ,
      CND_NE,
      CND_GTS,
      CND_LES,
      CND_GTU,
      CND_LEU
   } brn_cnd_e;

   typedef struct packed {
      brn_cls_e cls;
      brn_cnd_e cnd;
   } brn_ctl_t;

   typedef struct packed {
      logic eq;
      logic gt_s;
      logic gt_u;
   } brn_flags_t;

endpackage

// File: rtl/brn_decode.sv
module brn_decode
   import brn_pkg::*;
(
   input  logic [OPW-1:0] op_i,
   output brn_ctl_t       ctl_o
);

   always_comb begin
      ctl_o.cls = CLS_SEQ;
      ctl_o.cnd = CND_EQ;
      case (op_i)
         OP_STOP:  ctl_o.cls = CLS_HALT;
         OP_BRKPT: ctl_o.cls = CLS_PAUSE;
         OP_JMP:   ctl_o.cls = CLS_JMP;
         OP_JAL:   ctl_o.cls = CLS_LINK;
         OP_JR:    ctl_o.cls = CLS_REG;
         OP_BEQ:   begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_EQ;  end
         OP_BNE:   begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_NE;  end
         OP_BGTS:  begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_GTS; end
         OP_BLES:  begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_LES; end
         OP_BGTU:  begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_GTU; end
         OP_BLEU:  begin ctl_o.cls = CLS_COND; ctl_o.cnd = CND_LEU; end
         default:  ctl_o.cls = CLS_SEQ;
      endcase
   end

   // R11: gap opcodes must decode as sequential
   always_comb begin
      if (op_i >= 8'h0A && op_i <= 8'h0F) begin
         p_gap_seq_r11: assert (ctl_o.cls == CLS_SEQ)
            else $error("gap opcode decoded as control");
      end
   end

endmodule

// File: rtl/brn_compare.sv
module brn_compare
   import brn_pkg::*;
#(
   parameter int XLEN     = 32,
   parameter bit USE_SUB  = 1'b1
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   output brn_flags_t      flg_o
);

   localparam int MSB = XLEN - 1;

   initial begin
      if (XLEN < 2) $error("brn_compare: XLEN must be at least 2");
   end

   generate
      if (USE_SUB) begin : g_sub
         logic [XLEN:0] diff;
         logic          borrow;
         logic          is_eq;
         logic          lt_s;
         always_comb begin
            diff   = {1'b0, a_i} - {1'b0, b_i};
            borrow = diff[XLEN];
            is_eq  = (diff[MSB:0] == '0);
            lt_s   = (a_i[MSB] & ~b_i[MSB]) |
                     (~(a_i[MSB] ^ b_i[MSB]) & borrow);
            flg_o.eq   = is_eq;
            flg_o.gt_u = ~borrow & ~is_eq;
            flg_o.gt_s = ~lt_s & ~is_eq;
         end
      end else begin : g_direct
         always_comb begin
            flg_o.eq   = (a_i == b_i);
            flg_o.gt_u = (a_i > b_i);
            flg_o.gt_s = ($signed(a_i) > $signed(b_i));
         end
      end
   endgenerate

   always_comb begin
      p_eq_excl_r5: assert (!(flg_o.eq && (flg_o.gt_s || flg_o.gt_u)))
         else $error("equal operands flagged as greater");
      if (a_i[MSB] == b_i[MSB]) begin
         p_sign_agree_r6: assert (flg_o.gt_s == flg_o.gt_u)
            else $error("same-sign operands ordered differently");
      end
      if (a_i[MSB] != b_i[MSB]) begin
         p_sign_split_r7: assert (flg_o.gt_s != flg_o.gt_u)
            else $error("mixed-sign operands ordered alike");
      end
   end

endmodule

// File: rtl/brn_select.sv
module brn_select
   import brn_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int AW   = 16,
   parameter int IMMW = 16
) (
   input  brn_ctl_t        ctl_i,
   input  brn_flags_t      flg_i,
   input  logic [AW-1:0]   pc_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [IMMW-1:0] tgt_i,
   output logic [AW-1:0]   next_pc_o,
   output logic            taken_o,
   output logic            link_we_o,
   output logic [XLEN-1:0] link_val_o,
   output logic            halt_o,
   output logic            pause_o
);

   logic [AW-1:0] pc_inc;
   logic [AW-1:0] tgt_addr;
   logic          cond_hit;

   generate
      if (IMMW >= AW) begin : g_tgt_trunc
         assign tgt_addr = tgt_i[AW-1:0];
      end else begin : g_tgt_ext
         assign tgt_addr = {{(AW-IMMW){1'b0}}, tgt_i};
      end
   endgenerate

   assign pc_inc = pc_i + 1'b1;

   always_comb begin
      case (ctl_i.cnd)
         CND_EQ:  cond_hit =  flg_i.eq;
         CND_NE:  cond_hit = ~flg_i.eq;
         CND_GTS: cond_hit =  flg_i.gt_s;
         CND_LES: cond_hit = ~flg_i.gt_s;
         CND_GTU: cond_hit =  flg_i.gt_u;
         CND_LEU: cond_hit = ~flg_i.gt_u;
         default: cond_hit = 1'b0;
      endcase
   end

   always_comb begin
      next_pc_o  = pc_inc;
      taken_o    = 1'b0;
      link_we_o  = 1'b0;
      halt_o     = 1'b0;
      pause_o    = 1'b0;
      link_val_o = XLEN'(pc_inc);
      case (ctl_i.cls)
         CLS_JMP: begin
            next_pc_o = tgt_addr;
            taken_o   = 1'b1;
         end
         CLS_LINK: begin
            next_pc_o = tgt_addr;
            taken_o   = 1'b1;
            link_we_o = 1'b1;
         end
         CLS_REG: begin
            next_pc_o = rs1_i[AW-1:0];
            taken_o   = 1'b1;
         end
         CLS_COND: begin
            if (cond_hit) begin
               next_pc_o = tgt_addr;
               taken_o   = 1'b1;
            end
         end
         CLS_HALT:  halt_o  = 1'b1;
         CLS_PAUSE: pause_o = 1'b1;
         default: ;
      endcase
   end

   always_comb begin
      if (!taken_o) begin
         p_fallthru_r8: assert (next_pc_o == pc_i + 1'b1)
            else $error("not taken but next pc is not pc+1");
      end
      if (halt_o || pause_o) begin
         p_stop_quiet_r9: assert (!taken_o && !link_we_o)
            else $error("halt/pause redirected");
      end
   end

endmodule

// File: rtl/brn_nextpc_unit.sv
module brn_nextpc_unit
   import brn_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int AW      = 16,
   parameter int IMMW    = 16,
   parameter bit USE_SUB = 1'b1
) (
   input  logic [AW-1:0]   pc_i,
   input  logic [OPW-1:0]  op_i,
   input  logic [XLEN-1:0] rs1_i,
   input  logic [XLEN-1:0] rs2_i,
   input  logic [IMMW-1:0] tgt_i,
   output logic [AW-1:0]   next_pc_o,
   output logic            taken_o,
   output logic            link_we_o,
   output logic [XLEN-1:0] link_val_o,
   output logic            halt_o,
   output logic            pause_o
);

   initial begin
      if (AW < 2 || AW > XLEN) $error("brn_nextpc_unit: AW must lie in 2..XLEN");
      if (IMMW < 1)            $error("brn_nextpc_unit: IMMW must be positive");
   end

   brn_ctl_t   ctl;
   brn_flags_t flg;

   brn_decode u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   brn_compare #(.XLEN(XLEN), .USE_SUB(USE_SUB)) u_cmp (
      .a_i   (rs1_i),
      .b_i   (rs2_i),
      .flg_o (flg)
   );

   brn_select #(.XLEN(XLEN), .AW(AW), .IMMW(IMMW)) u_sel (
      .ctl_i      (ctl),
      .flg_i      (flg),
      .pc_i       (pc_i),
      .rs1_i      (rs1_i),
      .tgt_i      (tgt_i),
      .next_pc_o  (next_pc_o),
      .taken_o    (taken_o),
      .link_we_o  (link_we_o),
      .link_val_o (link_val_o),
      .halt_o     (halt_o),
      .pause_o    (pause_o)
   );

   always_comb begin
      p_excl_r12: assert ($onehot0({taken_o, halt_o, pause_o}))
         else $error("more than one of taken/halt/pause");
      p_link_taken_r12: assert (!link_we_o || taken_o)
         else $error("link write without redirect");
      if (link_we_o) begin
         p_link_value_r3: assert (link_val_o == XLEN'(AW'(pc_i + 1'b1)))
            else $error("link value is not pc+1");
      end
   end

endmodule

// File: tb/sim_brn_nextpc_unit.sv
module sim_brn_nextpc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] pc;
   logic [7:0]  op;
   logic [31:0] rs1, rs2;
   logic [15:0] tgt;
   logic [15:0] next_pc;
   logic        taken, link_we, halt, pause;
   logic [31:0] link_val;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   brn_nextpc_unit u0 (
      .pc_i(pc), .op_i(op), .rs1_i(rs1), .rs2_i(rs2), .tgt_i(tgt),
      .next_pc_o(next_pc), .taken_o(taken), .link_we_o(link_we),
      .link_val_o(link_val), .halt_o(halt), .pause_o(pause)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   function automatic string req_of(input logic [7:0] o);
      case (o)
         8'h01, 8'h82: return "R9";
         8'h02: return "R2";
         8'h03: return "R3";
         8'h04: return "R4";
         8'h05, 8'h06: return "R5";
         8'h07, 8'h08: return "R6";
         8'h09, 8'h10: return "R7";
         8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F: return "R11";
         default: return "R1";
      endcase
   endfunction

   function automatic bit cond_of(input logic [7:0] o, input logic [31:0] a, input logic [31:0] b);
      case (o)
         8'h05: return a == b;
         8'h06: return a != b;
         8'h07: return $signed(a) >  $signed(b);
         8'h08: return $signed(a) <= $signed(b);
         8'h09: return a >  b;
         8'h10: return a <= b;
         default: return 1'b0;
      endcase
   endfunction

   task automatic apply_check(input logic [7:0] o, input logic [15:0] p,
                              input logic [31:0] a, input logic [31:0] b,
                              input logic [15:0] t);
      logic [15:0] e_nx;
      logic        e_tk, e_lw, e_h, e_p;
      logic [15:0] inc;
      string       rq;
      op = o; pc = p; rs1 = a; rs2 = b; tgt = t;
      #1;
      inc  = p + 16'd1;
      e_nx = inc; e_tk = 0; e_lw = 0; e_h = 0; e_p = 0;
      rq   = req_of(o);
      case (o)
         8'h01: e_h = 1;
         8'h82: e_p = 1;
         8'h02: begin e_nx = t; e_tk = 1; end
         8'h03: begin e_nx = t; e_tk = 1; e_lw = 1; end
         8'h04: begin e_nx = a[15:0]; e_tk = 1; end
         8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h10: begin
            if (cond_of(o, a, b)) begin e_nx = t; e_tk = 1; end
         end
         default: ;
      endcase
      if (p == 16'hFFFF && !e_tk) rq = {rq, "/R10"};
      if (o >= 8'h05 && o <= 8'h10 && o != 8'h0A) rq = {rq, "/R8"};
      n_checks++;
      if ({next_pc, taken, link_we, halt, pause} != {e_nx, e_tk, e_lw, e_h, e_p}) begin
         n_fail++;
         $display("FAIL %s op=%h a=%h b=%h: actual nx=%h tk=%b lw=%b h=%b p=%b expected nx=%h tk=%b lw=%b h=%b p=%b",
                  rq, o, a, b, next_pc, taken, link_we, halt, pause, e_nx, e_tk, e_lw, e_h, e_p);
      end
      if (e_lw) begin
         n_checks++;
         if (link_val != {16'h0, inc}) begin
            n_fail++;
            $display("FAIL R3 link value: actual %h expected %h", link_val, {16'h0, inc});
         end
      end
      n_checks++;
      if (!$onehot0({taken, halt, pause}) || (link_we && !taken)) begin
         n_fail++;
         $display("FAIL R12 exclusivity: actual tk=%b h=%b p=%b lw=%b expected at most one, link only when taken",
                  taken, halt, pause, link_we);
      end
      #1;
   endtask

   localparam logic [31:0] BND [4] = '{32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h00000000};
   localparam logic [7:0]  CNDOP [6] = '{8'h05, 8'h06, 8'h07, 8'h08, 8'h09, 8'h10};
   localparam logic [7:0]  ALLOP [14] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                                          8'h08, 8'h09, 8'h10, 8'h82, 8'h21, 8'h0C, 8'h70};

   initial begin
      op = 8'h00; pc = 16'h0; rs1 = '0; rs2 = '0; tgt = '0;
      #9 rst_n = 1'b1;
      // R1 reset/idle state: opcode 0 falls through
      apply_check(8'h00, 16'h0000, 32'h0, 32'h0, 16'h1234);
      // R2 jump ignores registers
      apply_check(8'h02, 16'h0010, 32'hDEADBEEF, 32'h1, 16'hABCD);
      // R3 link, including wrap (R10)
      apply_check(8'h03, 16'h0100, 32'h0, 32'h0, 16'h0040);
      apply_check(8'h03, 16'hFFFF, 32'h0, 32'h0, 16'h0002);
      // R4 jump to register, upper bits dropped
      apply_check(8'h04, 16'h0005, 32'h1234_8765, 32'h0, 16'h0);
      // R9 stop and breakpoint
      apply_check(8'h01, 16'h0200, 32'h5, 32'h5, 16'h0300);
      apply_check(8'h82, 16'hFFFF, 32'h5, 32'h5, 16'h0300);
      // R10 wrap on fall-through
      apply_check(8'h21, 16'hFFFF, 32'h0, 32'h0, 16'h0);
      // R11 gap opcodes
      for (int g = 8'h0A; g <= 8'h0F; g++)
         apply_check(8'(g), 16'h0042, 32'h1, 32'h1, 16'h0777);
      // R5 R6 R7 R8 boundary values for every condition
      for (int c = 0; c < 6; c++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               apply_check(CNDOP[c], 16'h0300, BND[i], BND[j], 16'h0ABC);
      // random mix, fixed seed
      void'($urandom(32'd2024));
      for (int k = 0; k < 2000; k++) begin
         logic [31:0] a, b;
         a = $urandom();
         b = ($urandom() % 4 == 0) ? a : $urandom();
         apply_check(ALLOP[$urandom() % 14], 16'($urandom()), a, b, 16'($urandom()));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule